// File: doc/BRIEF.md
# Slow Oscillator Period Measurement and Trim Loop

This block measures the period of a slow on-chip oscillator in units of a fast, trusted reference clock and keeps the oscillator inside a programmed period window by nudging a 4-bit trim code. The slow clock is brought into the reference domain through a synchronizer and an edge detector. Each synchronized rising edge copies a free-running reference counter into a capture register. The difference between two successive captures is the period, and it is published together with a one-cycle valid strobe.

A controller compares each period against `target ± tolerance`. It only knows which way the trim acts: a higher code gives a slower oscillator (a longer period) and a lower code gives a faster one. The size of each step is unknown and not uniform, so the controller moves the code by one LSB at a time. After each move it throws away the next measurement, because that interval spans the change, and only then decides again. A lock flag reports a settled oscillator.

Top module: `osc_trim_loop`

## Requirements
- R1: Out of reset `trim_o` equals the preset `TRIM_RESET` (default 8, 1000b), `locked_o` is 0, `period_valid_o` is 0 and `period_o` is 0.
- R2: `slow_clk_i` passes through a two-flop synchronizer and a rising-edge detector. Each detected edge captures the free-running reference counter. From the second edge onward, `period_o` is set to the current capture minus the previous one (modulo 2^CNT_W), and `period_valid_o` pulses high for exactly one cycle. The first edge after reset produces no strobe.
- R3: A non-discarded measurement with `period_o > target_i + tol_i` lowers `trim_o` by exactly 1 in the cycle after the strobe.
- R4: A non-discarded measurement with `period_o < target_i - tol_i` raises `trim_o` by exactly 1 in the cycle after the strobe. If `tol_i > target_i`, the lower bound is 0.
- R5: The trim code saturates: a too-long period at code 0 leaves it at 0, and a too-short period at code 15 leaves it at 15. A saturated case does not count as a trim change.
- R6: The first measurement after any trim change is discarded. It changes neither `trim_o` nor the lock state.
- R7: `locked_o` rises after 3 consecutive in-window, non-discarded measurements. It clears on the first out-of-window, non-discarded measurement.
- R8: The window bounds are inclusive. A period equal to `target_i - tol_i` or `target_i + tol_i` is in window and leaves `trim_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_clk_i | input | 1 | Slow oscillator output, asynchronous to clk_i |
| target_i | input | CNT_W | Target period in reference ticks |
| tol_i | input | CNT_W | Allowed deviation from target in ticks |
| trim_o | output | TRIM_W | Trim code driven to the oscillator |
| period_o | output | CNT_W | Last measured slow-clock period |
| period_valid_o | output | 1 | One-cycle strobe when period_o is updated |
| locked_o | output | 1 | Oscillator is settled inside the window |

## Verification
A corrupted capture register or counter shows up at `period_o` on the very next strobe, because the reported period then differs from the interval the bench generated. A wrong discard flag or comparison shows up one cycle after a strobe, as a trim move that is missing, extra, or in the wrong direction. Because the oscillator model reacts to the trim, one such slip also shifts every later period. A stale lock counter shows up as `locked_o` changing on the wrong strobe, at the latest three measurements later.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [1:0] {
    VERDICT_IN    = 2'd0,
    VERDICT_LONG  = 2'd1,
    VERDICT_SHORT = 2'd2
  } verdict_e;
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], async_i};
  end

  // top stage only delays the synchronized level for edge detection
  assign rise_o = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];

  a_r2_rise_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/osc_period_capture.sv
module osc_period_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] period_o,
  output logic             valid_o
);
  logic [CNT_W-1:0] cnt_q, cap_q, per_q;
  logic             have_q, valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cap_q   <= '0;
      per_q   <= '0;
      have_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      valid_q <= 1'b0;
      if (rise_i) begin
        cap_q  <= cnt_q;
        have_q <= 1'b1;
        if (have_q) begin
          per_q   <= cnt_q - cap_q;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign period_o = per_q;
  assign valid_o  = valid_q;

  a_r2_valid_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rise_i));
  a_r2_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r2_period_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(period_o));
endmodule

// File: rtl/osc_period_window.sv
module osc_period_window
  import osc_trim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic [CNT_W-1:0] tol_i,
  output verdict_e         verdict_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] hi, lo, per_x;

  always_comb begin
    per_x = {1'b0, period_i};
    hi    = {1'b0, target_i} + {1'b0, tol_i};
    lo    = (tol_i > target_i) ? '0 : ({1'b0, target_i} - {1'b0, tol_i});
    if (per_x > hi)      verdict_o = VERDICT_LONG;
    else if (per_x < lo) verdict_o = VERDICT_SHORT;
    else                 verdict_o = VERDICT_IN;
  end
endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int TRIM_W     = 4,
  parameter int TRIM_RESET = 8,
  parameter int LOCK_N     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  verdict_e          verdict_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              locked_o
);
  localparam int                LOCK_W   = $clog2(LOCK_N + 1);
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;
  localparam logic [TRIM_W-1:0] TRIM_ONE = {{(TRIM_W-1){1'b0}}, 1'b1};
  localparam logic [LOCK_W-1:0] LOCK_TOP = LOCK_W'(LOCK_N);
  localparam logic [LOCK_W-1:0] LOCK_ONE = {{(LOCK_W-1){1'b0}}, 1'b1};

  logic [TRIM_W-1:0] trim_q;
  logic [LOCK_W-1:0] lock_q;
  logic              skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q <= TRIM_W'(TRIM_RESET);
      lock_q <= '0;
      skip_q <= 1'b0;
    end else if (valid_i) begin
      if (skip_q) begin
        skip_q <= 1'b0;  // interval straddled the last trim step
      end else begin
        unique case (verdict_i)
          VERDICT_LONG: begin
            lock_q <= '0;
            if (trim_q != '0) begin
              trim_q <= trim_q - TRIM_ONE;
              skip_q <= 1'b1;
            end
          end
          VERDICT_SHORT: begin
            lock_q <= '0;
            if (trim_q != TRIM_MAX) begin
              trim_q <= trim_q + TRIM_ONE;
              skip_q <= 1'b1;
            end
          end
          default: begin
            if (lock_q != LOCK_TOP) lock_q <= lock_q + LOCK_ONE;
          end
        endcase
      end
    end
  end

  assign trim_o   = trim_q;
  assign locked_o = (lock_q == LOCK_TOP);

  a_r3_trim_only_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(trim_q));
  a_r5_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trim_q) |-> (({1'b0, trim_q} == {1'b0, $past(trim_q)} + 1) ||
                          ({1'b0, trim_q} + 1 == {1'b0, $past(trim_q)})));
  a_r6_discard_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && skip_q) |=> ($stable(trim_q) && $stable(locked_o)));
  a_r7_lock_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !skip_q && verdict_i != VERDICT_IN) |=> !locked_o);
  a_r8_in_window_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && verdict_i == VERDICT_IN) |=> $stable(trim_q));
endmodule

// File: rtl/osc_trim_loop.sv
module osc_trim_loop
  import osc_trim_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TRIM_W     = 4,
  parameter int TRIM_RESET = 8,
  parameter int LOCK_N     = 3,
  parameter int SYNC_N     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_clk_i,
  input  logic [CNT_W-1:0]  target_i,
  input  logic [CNT_W-1:0]  tol_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              period_valid_o,
  output logic              locked_o
);
  logic     rise;
  verdict_e verdict;

  osc_edge_sync #(.SYNC_N(SYNC_N)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (slow_clk_i),
    .rise_o  (rise)
  );

  osc_period_capture #(.CNT_W(CNT_W)) i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .period_o (period_o),
    .valid_o  (period_valid_o)
  );

  osc_period_window #(.CNT_W(CNT_W)) i_window (
    .period_i  (period_o),
    .target_i  (target_i),
    .tol_i     (tol_i),
    .verdict_o (verdict)
  );

  osc_trim_ctrl #(
    .TRIM_W     (TRIM_W),
    .TRIM_RESET (TRIM_RESET),
    .LOCK_N     (LOCK_N)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (period_valid_o),
    .verdict_i (verdict),
    .trim_o    (trim_o),
    .locked_o  (locked_o)
  );

  a_r1_no_early_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(period_valid_o));
endmodule

// File: tb/test_osc_trim_loop.sv
module test_osc_trim_loop;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int TRIM_W     = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              slow_clk = 1'b0;
  logic [CNT_W-1:0]  target = 16'd70;
  logic [CNT_W-1:0]  tol = 16'd3;
  logic [TRIM_W-1:0] trim;
  logic [CNT_W-1:0]  period;
  logic              period_valid;
  logic              locked;

  int errors = 0;
  int checks = 0;
  int n_meas = 0;
  bit running = 1'b0;
  int exp_q[$];

  // bench reference of the control rules
  int m_trim = 8;
  int m_lock = 0;
  bit m_skip = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_trim_loop i_osc_trim_loop (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .slow_clk_i     (slow_clk),
    .target_i       (target),
    .tol_i          (tol),
    .trim_o         (trim),
    .period_o       (period),
    .period_valid_o (period_valid),
    .locked_o       (locked)
  );

  // higher code -> longer period, step grows above code 8
  function automatic int osc_period(int code);
    return 40 + 3 * code + ((code > 8) ? 2 * (code - 8) : 0);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: trim-controlled slow oscillator, pushes each generated period
  initial begin
    wait (running);
    forever begin
      int p;
      @(negedge clk);
      p = osc_period(int'(trim));
      slow_clk = 1'b1;
      repeat (p / 2 - 1) @(negedge clk);
      @(negedge clk);
      slow_clk = 1'b0;
      repeat (p - p / 2 - 1) @(negedge clk);
      exp_q.push_back(p);
    end
  end

  // monitor: compares period and the trim/lock response of the next cycle
  initial begin
    bit pend = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (pend) begin
        check("R3/R4/R5/R6 trim", int'(trim), m_trim);
        check("R7 locked", int'(locked), (m_lock == 3) ? 1 : 0);
        pend = 1'b0;
      end
      if (period_valid) begin
        int p, hi, lo;
        if (exp_q.size() == 0) begin
          check("R2 unexpected strobe", 1, 0);
          p = -1;
        end else begin
          p = exp_q.pop_front();
          check("R2 period", int'(period), p);
        end
        hi = int'(target) + int'(tol);
        lo = (tol > target) ? 0 : int'(target) - int'(tol);
        if (m_skip) m_skip = 1'b0;
        else if (int'(period) > hi) begin
          m_lock = 0;
          if (m_trim > 0) begin m_trim--; m_skip = 1'b1; end
        end else if (int'(period) < lo) begin
          m_lock = 0;
          if (m_trim < 15) begin m_trim++; m_skip = 1'b1; end
        end else if (m_lock < 3) m_lock++;
        pend = 1'b1;
        n_meas++;
      end
    end
  end

  task automatic run_meas(int n);
    int goal = n_meas + n;
    wait (n_meas >= goal);
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 trim reset", int'(trim), 8);
    check("R1 locked reset", int'(locked), 0);
    check("R1 valid reset", int'(period_valid), 0);
    check("R1 period reset", int'(period), 0);
    rst_ni = 1'b1;
    running = 1'b1;

    // window 67..73: code 8 gives 64 (short), code 9 gives 69
    run_meas(8);
    check("R4 settled code", int'(trim), 9);
    check("R7 lock reached", int'(locked), 1);

    // window 98..102: walk up to code 15 (period 99)
    target = 16'd100; tol = 16'd2;
    run_meas(20);
    check("R4 walk up", int'(trim), 15);
    check("R7 relock", int'(locked), 1);

    // unreachable long target: stays saturated at 15
    target = 16'd200; tol = 16'd5;
    run_meas(5);
    check("R5 top saturation", int'(trim), 15);
    check("R7 lock cleared", int'(locked), 0);

    // short target: walk down to 0 and hold
    target = 16'd30; tol = 16'd1;
    run_meas(36);
    check("R3 walk down", int'(trim), 0);
    check("R5 bottom saturation", int'(trim), 0);

    // tolerance above target: lower bound clamps to 0, still too long
    target = 16'd2; tol = 16'd5;
    run_meas(3);
    check("R4 clamped low bound", int'(trim), 0);

    // period 40 exactly on lower bound
    target = 16'd45; tol = 16'd5;
    run_meas(4);
    check("R8 low bound inclusive", int'(trim), 0);
    check("R8 lock on bound", int'(locked), 1);

    // period 40 exactly on upper bound
    target = 16'd37; tol = 16'd3;
    run_meas(3);
    check("R8 high bound inclusive", int'(trim), 0);
    check("R7 lock held", int'(locked), 1);

    finish_run();
  end
endmodule